// File: doc/BRIEF.md
# Dual-Mode Shifted Multiply-Accumulate Processing Element

This block is one processing element of an output-stationary systolic array. In every cycle it receives one 8-bit activation slot word, two signed 8-bit weights and a small set of quantizer metadata. It multiplies the slot contents by the weights and adds the result to a locally held 32-bit partial sum. It also passes all of its operands to the next element downstream after one register stage.

The datapath is built from two 4b×8b multiplier lanes. Each lane has its own left shifter, and multiplexers in front of the lanes pick the weights. In paired mode the slot word holds two independent 4-bit activations. Each activation is shifted by the placement its window identifier selects and is multiplied by its own weight. In pass-through mode the slot word holds a single 8-bit activation. The upper nibble lane is shifted by four and the lower nibble lane by zero, and both lanes use the one selected weight, so the sum is the exact 8b×8b product. A synchronous clear empties the partial sum between tiles. The sum can be read on the output at any time.

Top module: `dmac_pe`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock edge) is active, the next clock edge sets `psum` and every forwarded output to zero.
- R2: When `pair_i` is 0 and `vld_i` is 1, `psum` grows by `act_i` (unsigned, 0..255) times the selected weight. `wsel_i`=0 selects `w1_i` and `wsel_i`=1 selects `w2_i`. The window identifiers have no effect in this mode.
- R3: When `pair_i` is 1 and `vld_i` is 1, `psum` grows by `(act_i[7:4] << s(win_hi_i)) * w1_i + (act_i[3:0] << s(win_lo_i)) * w2_i`. The nibbles are unsigned and the weights are signed. `wsel_i` has no effect in this mode.
- R4: The window shift is s(id) = id × 4/(WIN_OPTS−1), and any id ≥ WIN_OPTS gives a shift of 4. With the default WIN_OPTS=5, ids 0..4 shift by 0..4 and ids 5..7 shift by 4.
- R5: When `vld_i` is 0 and `clr_i` is 0, `psum` keeps its value whatever the other inputs carry.
- R6: When `clr_i` is 1, `psum` is zero after the next edge, even if `vld_i` is 1 in the same cycle.
- R7: Each of `act_i`, `w1_i`, `w2_i`, `pair_i`, `wsel_i`, `win_hi_i`, `win_lo_i` and `vld_i` appears on its `_o` counterpart exactly one cycle later. This happens whatever the values of `clr_i` and `vld_i`.
- R8: `psum` is a 32-bit two's-complement sum and updates one edge after the operands are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the partial sum |
| vld_i | input | 1 | Operands valid; accumulate this cycle |
| act_i | input | 8 | Activation slot word |
| w1_i | input | 8 | Signed weight for the upper lane |
| w2_i | input | 8 | Signed weight for the lower lane |
| pair_i | input | 1 | 1 = two 4-bit activations, 0 = one 8-bit activation |
| wsel_i | input | 1 | Pass-through weight choice (0 = w1, 1 = w2) |
| win_hi_i | input | 3 | Window identifier of the upper nibble |
| win_lo_i | input | 3 | Window identifier of the lower nibble |
| act_o | output | 8 | Forwarded activation slot word |
| w1_o | output | 8 | Forwarded weight 1 |
| w2_o | output | 8 | Forwarded weight 2 |
| pair_o | output | 1 | Forwarded mode flag |
| wsel_o | output | 1 | Forwarded weight choice |
| win_hi_o | output | 3 | Forwarded upper window identifier |
| win_lo_o | output | 3 | Forwarded lower window identifier |
| vld_o | output | 1 | Forwarded valid |
| psum | output | 32 | Stationary partial sum |

## Verification
The bench compares `psum` against a behavioural model at every clock. A wrong shift, a wrong weight choice or a wrong sign in either lane therefore shows up one edge after the offending operands arrive. It does not wait until a tile drain. The partial sum is never reset between operations except by `clr_i`, so a single bad update stays visible on every later cycle until the next clear. A fault in the forwarding stage shows on the `_o` ports one cycle after the inputs. Directed cases cover the exact 8-bit product, negative weights, weight choice, identifier clamping and a clear that arrives in the same cycle as valid data. A long stretch of mixed random traffic follows them.

// File: rtl/dmac_pkg.sv
// Package: shared widths and the window-identifier-to-shift mapping for
// the dual-mode MAC processing element.
// Assumes the activation is twice the nibble width.
package dmac_pkg;

    localparam int ACT_W  = 8;
    localparam int NIB_W  = ACT_W / 2;
    localparam int MAX_SH = ACT_W - NIB_W;
    localparam int SH_W   = $clog2(MAX_SH + 1);

    // Map a window identifier to a left-shift amount for a given option count.
    function automatic logic [SH_W-1:0] win_to_shift(input int id, input int opts);
        int step;
        step = MAX_SH / (opts - 1);
        if (id >= opts - 1) return SH_W'(MAX_SH);
        return SH_W'(id * step);
    endfunction

endpackage

// File: rtl/dmac_lane.sv
// Module: dmac_lane
// One 4b x 8b multiplier lane followed by a dynamic left shift.
// Assumes an unsigned nibble, a signed weight and a shift of at most MAX_SH.
// The output is sign-extended wide enough that the shift never loses bits.
module dmac_lane #(
    parameter int NIB_W  = 4,
    parameter int WGT_W  = 8,
    parameter int SH_W   = 3,
    parameter int MAX_SH = 4,
    localparam int RAW_W = NIB_W + WGT_W + 1,
    localparam int OUT_W = RAW_W + MAX_SH
) (
    input  logic [NIB_W-1:0]        nib,
    input  logic signed [WGT_W-1:0] wgt,
    input  logic [SH_W-1:0]         sh,
    output logic signed [OUT_W-1:0] prod
);

    logic signed [RAW_W-1:0] raw;
    logic signed [OUT_W-1:0] ext;

    // Multiply the zero-extended nibble by the signed weight.
    always_comb raw = $signed({1'b0, nib}) * wgt;

    // Sign-extend the raw product and apply the window shift.
    always_comb begin
        ext  = {{MAX_SH{raw[RAW_W-1]}}, raw};
        prod = ext <<< sh;
    end

endmodule

// File: rtl/dmac_acc.sv
// Module: dmac_acc
// Output-stationary partial-sum register with synchronous clear.
// Assumes the lane sum is already sign-extended to ACC_W by the caller.
// Clear takes priority over accumulation, and the sum wraps modulo 2^ACC_W.
module dmac_acc #(
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] addend,
    output logic signed [ACC_W-1:0] acc
);

    // Hold, clear or add the incoming product on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= acc + addend;
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (acc == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && !$past(en)) |-> $stable(acc));

    assert_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $past(en)) |-> (acc == $past(acc) + $past(addend)));

endmodule

// File: rtl/dmac_fwd.sv
// Module: dmac_fwd
// One-cycle register stage that passes operands to the downstream element.
// Assumes every forwarded field is packed into a single vector by the caller.
module dmac_fwd #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Register the operand bundle and clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_fwd_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q == $past(d)));

endmodule

// File: rtl/dmac_pe.sv
// Module: dmac_pe
// Dual-mode processing element. It computes either one 8b x 8b product or two
// shifted 4b x 8b products per cycle and accumulates them in place.
// Operands are forwarded downstream after one register stage.
// Assumes WIN_OPTS is 2, 3 or 5, so that 4/(WIN_OPTS-1) is an integer.
module dmac_pe
    import dmac_pkg::*;
#(
    parameter int WGT_W    = 8,
    parameter int ACC_W    = 32,
    parameter int WIN_OPTS = 5,
    parameter int ID_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    vld_i,
    input  logic [ACT_W-1:0]        act_i,
    input  logic signed [WGT_W-1:0] w1_i,
    input  logic signed [WGT_W-1:0] w2_i,
    input  logic                    pair_i,
    input  logic                    wsel_i,
    input  logic [ID_W-1:0]         win_hi_i,
    input  logic [ID_W-1:0]         win_lo_i,
    output logic [ACT_W-1:0]        act_o,
    output logic signed [WGT_W-1:0] w1_o,
    output logic signed [WGT_W-1:0] w2_o,
    output logic                    pair_o,
    output logic                    wsel_o,
    output logic [ID_W-1:0]         win_hi_o,
    output logic [ID_W-1:0]         win_lo_o,
    output logic                    vld_o,
    output logic signed [ACC_W-1:0] psum
);

    localparam int LANES  = 2;
    localparam int LP_W   = NIB_W + WGT_W + 1 + MAX_SH;
    localparam int SUM_W  = LP_W + 1;
    localparam int STEP   = MAX_SH / (WIN_OPTS - 1);
    localparam int FWD_W  = ACT_W + 2 * WGT_W + 3 + 2 * ID_W;

    logic [NIB_W-1:0]        nib  [LANES];
    logic signed [WGT_W-1:0] wsel [LANES];
    logic [SH_W-1:0]         sh   [LANES];
    logic signed [LP_W-1:0]  lp   [LANES];
    logic signed [SUM_W-1:0] lane_sum;
    logic signed [ACC_W-1:0] addend;
    logic signed [WGT_W-1:0] pass_w;

    // Choose the single weight that both lanes use in pass-through mode.
    always_comb pass_w = wsel_i ? w2_i : w1_i;

    // Lane 1 carries the upper nibble and lane 0 the lower one.
    // Each lane gets its weight and shift from the mode.
    always_comb begin
        nib[1] = act_i[ACT_W-1:NIB_W];
        nib[0] = act_i[NIB_W-1:0];
        if (pair_i) begin
            wsel[1] = w1_i;
            wsel[0] = w2_i;
            sh[1]   = win_to_shift(int'(win_hi_i), WIN_OPTS);
            sh[0]   = win_to_shift(int'(win_lo_i), WIN_OPTS);
        end else begin
            wsel[1] = pass_w;
            wsel[0] = pass_w;
            sh[1]   = SH_W'(MAX_SH);
            sh[0]   = '0;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmac_lane #(
            .NIB_W (NIB_W),
            .WGT_W (WGT_W),
            .SH_W  (SH_W),
            .MAX_SH(MAX_SH)
        ) u_lane (
            .nib (nib[g]),
            .wgt (wsel[g]),
            .sh  (sh[g]),
            .prod(lp[g])
        );

        assert_shift_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sh[g]) <= MAX_SH) && ((int'(sh[g]) % STEP) == 0));
    end

    // Add the two lane products and sign-extend the sum to accumulator width.
    always_comb begin
        lane_sum = SUM_W'(lp[1]) + SUM_W'(lp[0]);
        addend   = {{(ACC_W-SUM_W){lane_sum[SUM_W-1]}}, lane_sum};
    end

    dmac_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_i),
        .en    (vld_i),
        .addend(addend),
        .acc   (psum)
    );

    dmac_fwd #(.W(FWD_W)) u_fwd (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({act_i, w1_i, w2_i, pair_i, wsel_i, vld_i, win_hi_i, win_lo_i}),
        .q    ({act_o, w1_o, w2_o, pair_o, wsel_o, vld_o, win_hi_o, win_lo_o})
    );

    assert_pass_equiv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_i |-> (lane_sum == SUM_W'($signed({1'b0, act_i}) * pass_w)));

endmodule

// File: tb/tb_dmac_pe.sv
// Bench for dmac_pe. A behavioural model of the partial sum and of the
// forwarding stage is compared against the outputs on every cycle.
module tb_dmac_pe;

    localparam int OPTS = 5;
    localparam int IDW  = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic              rst_n = 1'b0, clr_i = 1'b0, vld_i = 1'b0;
    logic [7:0]        act_i = '0;
    logic signed [7:0] w1_i = '0, w2_i = '0;
    logic              pair_i = 1'b0, wsel_i = 1'b0;
    logic [IDW-1:0]    win_hi_i = '0, win_lo_i = '0;
    logic [7:0]        act_o;
    logic signed [7:0] w1_o, w2_o;
    logic              pair_o, wsel_o, vld_o;
    logic [IDW-1:0]    win_hi_o, win_lo_o;
    logic signed [31:0] psum;

    dmac_pe #(.WIN_OPTS(OPTS), .ID_W(IDW)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i), .act_i(act_i),
        .w1_i(w1_i), .w2_i(w2_i), .pair_i(pair_i), .wsel_i(wsel_i),
        .win_hi_i(win_hi_i), .win_lo_i(win_lo_i), .act_o(act_o), .w1_o(w1_o),
        .w2_o(w2_o), .pair_o(pair_o), .wsel_o(wsel_o), .win_hi_o(win_hi_o),
        .win_lo_o(win_lo_o), .vld_o(vld_o), .psum(psum)
    );

    int checks = 0, fails = 0;
    int ref_acc = 0;
    bit done = 1'b0;

    // Shift amount for a window identifier: id * 4/(OPTS-1), clamped at 4.
    function automatic int ref_shift(int id);
        if (id >= OPTS) return 4;
        return id * (4 / (OPTS - 1));
    endfunction

    // Expected product for the current inputs.
    function automatic int ref_prod();
        int a, hi, lo;
        a = int'(act_i);
        if (!pair_i) return a * (wsel_i ? int'(w2_i) : int'(w1_i));
        hi = (a / 16) * (1 << ref_shift(int'(win_hi_i)));
        lo = (a % 16) * (1 << ref_shift(int'(win_lo_i)));
        return hi * int'(w1_i) + lo * int'(w2_i);
    endfunction

    // Advance one clock; compare psum and the forwarded bundle with the model.
    task automatic tick(string req);
        logic [31:0] exp_fwd;
        logic [31:0] got_fwd;
        if (!rst_n) begin
            ref_acc = 0;
            exp_fwd = '0;
        end else begin
            if (clr_i)      ref_acc = 0;
            else if (vld_i) ref_acc = ref_acc + ref_prod();
            exp_fwd = {act_i, w1_i, w2_i, pair_i, wsel_i, vld_i, win_hi_i, win_lo_i, 1'b0};
        end
        @(negedge clk);
        got_fwd = {act_o, w1_o, w2_o, pair_o, wsel_o, vld_o, win_hi_o, win_lo_o, 1'b0};
        checks++;
        if (psum !== ref_acc) begin
            fails++;
            $display("FAIL %s psum actual=%0d expected=%0d", req, psum, ref_acc);
        end else if (got_fwd !== exp_fwd) begin
            fails++;
            $display("FAIL R7 forward actual=%h expected=%h", got_fwd, exp_fwd);
        end
    endtask

    // Present one set of operands at the negedge, then advance a clock.
    task automatic op(bit v, bit c, bit p, bit ws, logic [7:0] a, int wa, int wb,
                      int hi, int lo, string req);
        vld_i = v; clr_i = c; pair_i = p; wsel_i = ws; act_i = a;
        w1_i = 8'(wa); w2_i = 8'(wb); win_hi_i = IDW'(hi); win_lo_i = IDW'(lo);
        tick(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset clears sum and forwarded outputs, even with traffic present.
        act_i = 8'hFF; w1_i = 8'sd5; vld_i = 1'b1;
        tick("R1");
        tick("R1");
        rst_n = 1'b1;
        // R2: pass-through, 27 * 3 with weight 1 chosen; window ids ignored.
        op(1, 0, 0, 0, 8'd27, 3, 99, 7, 2, "R2");
        // R2: pass-through with weight 2 chosen, negative value, full-scale act.
        op(1, 0, 0, 1, 8'd255, 100, -128, 0, 0, "R2");
        // R3: paired, 0x1B with ids 1/3 and weights 7/-2; wsel ignored.
        op(1, 0, 1, 1, 8'h1B, 7, -2, 1, 3, "R3");
        // R4: ids beyond the last placement clamp to shift 4.
        op(1, 0, 1, 0, 8'hF9, -1, 3, 6, 5, "R4");
        op(1, 0, 1, 0, 8'h81, 127, 127, 4, 0, "R4");
        // R5: valid low holds the sum while other inputs change.
        op(0, 0, 1, 1, 8'hFF, -128, -128, 4, 4, "R5");
        op(0, 0, 0, 0, 8'h55, 127, 1, 0, 0, "R5");
        // R6: clear in the same cycle as valid wins.
        op(1, 1, 0, 0, 8'd200, 50, 0, 0, 0, "R6");
        op(1, 0, 0, 0, 8'd1, -1, 0, 0, 0, "R8");
        op(0, 1, 0, 0, 8'd0, 0, 0, 0, 0, "R6");
        // Mixed random traffic covering R2, R3, R4, R5, R6, R7 and R8.
        for (int i = 0; i < 600; i++) begin
            op($urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0,
               1'($urandom), 1'($urandom), 8'($urandom),
               $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
               $urandom_range(0, 7), $urandom_range(0, 7), "R3");
        end
        // R1: reset again in mid-run clears everything.
        rst_n = 1'b0;
        tick("R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule